// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the programming front end of one eight-level legacy interrupt controller. It accepts byte-wide writes and reads on a two-address port, where the `addr_odd` line picks the command address (low) or the data address (high). It walks software through a fixed four-word initialization handshake. It rejects set-ups the controller cannot honour, and then holds the operating configuration: the vector base, the auto-EOI and special fully-nested flags, special mask mode, the read selection and a pending poll command, together with the eight-bit mask register.

Priority resolution and pin sensing sit in a neighbouring block. That block supplies the request and in-service vectors and the currently winning eligible level. This decoder sends back two kinds of single-cycle command: an end-of-interrupt or priority command carrying a three-bit level, and a poll acknowledge. It also raises a strobe whenever initialization restarts, so that the neighbour can return its lowest-priority level to 7. Reads return data one cycle after the request, and the `IS_MASTER` parameter states whether this instance sits at the head of a cascade.

Top module: `intc_cmd_decoder`

## Requirements
- R1: After reset the block is not ready, and the mask, the vector base, every mode flag, the poll flag, `rd_data` and all strobes are zero, with the request register selected for command-address reads.
- R2: A write to the command address with bit 4 set starts initialization. From the next cycle the mask, special mask mode and the poll flag are cleared, the request register is selected, `ready` is low, and `init_stb` pulses for one cycle.
- R3: A start word with bit 1 (single controller) set or bit 0 (fourth word needed) clear is an error. Initialization then does not proceed, `ready` stays low, and the following data-address writes load the mask.
- R4: After a good start word, the next three data-address writes are taken in order as the base word, the cascade word and the mode word. The base word loads `vec_base` from bits 7:3 and ignores bits 2:0, and the cascade word changes no output.
- R5: A mode word with bit 0 clear is rejected: `ready` stays low and the next data-address write is again taken as the mode word. An accepted mode word sets `ready`, loads `aeoi_en` from bit 1, and loads `sfn_en` from bit 4 only when `IS_MASTER` is 1 (otherwise zero).
- R6: Once ready, a command-address write with bits 4 and 3 clear pulses `cmd_stb` in the next cycle, with `cmd_rot`=bit 7, `cmd_sl`=bit 6, `cmd_eoi`=bit 5 and `cmd_lvl`=bits 2:0.
- R7: Once ready, a command-address write with bit 3 set and bit 4 clear updates special mask mode to bit 5 only when bit 6 is set. When bit 1 is set, it selects the in-service register for reads if bit 0 is 1 (request register if 0) and arms polling from bit 2.
- R8: A read while polling is armed clears the poll flag, at either address. If `best_valid` is high the read returns 0x80 ORed with `best_lvl` and pulses `ack_stb` with `ack_lvl`=`best_lvl`; otherwise it returns 0 and no acknowledge occurs.
- R9: A read without polling returns the mask at the data address, and the selected in-service or request vector at the command address.
- R10: While not ready, a command-address write with bit 4 clear changes nothing and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr_odd | input | 1 | 0 selects the command address, 1 the data address |
| wr_data | input | 8 | Write byte |
| irr_in | input | 8 | Request vector from the priority block |
| isr_in | input | 8 | In-service vector from the priority block |
| best_valid | input | 1 | An eligible request exists |
| best_lvl | input | 3 | Winning eligible level |
| rd_data | output | 8 | Read result, registered |
| ready | output | 1 | Initialization complete |
| vec_base | output | 5 | Vector base (upper five bits) |
| aeoi_en | output | 1 | Auto end-of-interrupt enabled |
| sfn_en | output | 1 | Special fully-nested mode enabled |
| smm_en | output | 1 | Special mask mode enabled |
| mask_out | output | 8 | Mask register |
| init_stb | output | 1 | Initialization restarted |
| cmd_stb | output | 1 | EOI / priority command strobe |
| cmd_rot | output | 1 | Command rotate flag |
| cmd_sl | output | 1 | Command specific-level flag |
| cmd_eoi | output | 1 | Command end-of-interrupt flag |
| cmd_lvl | output | 3 | Command level |
| ack_stb | output | 1 | Poll acknowledge strobe |
| ack_lvl | output | 3 | Acknowledged level |

## Verification
The in-line assertions check several properties on every cycle. A bad start word lands in the error step. `ready` rises only from an accepted mode word. A start word leaves the mask and poll flag cleared. Every command strobe and acknowledge traces back to the write or poll read that caused it, and a poll read disarms polling. Other behaviour can only be shown by the bench scenarios, which compare against the reference model:

- the exact field-by-field decode of the base, mode and command words;
- retrying a rejected mode word;
- the special-mask enable gating;
- master versus cascaded handling of the fully-nested bit;
- read data selection across sequences of configuration writes.

// File: rtl/intc_cmd_pkg.sv
package intc_cmd_pkg;

  typedef enum logic [2:0] {
    STEP_OP   = 3'd0,
    STEP_FAIL = 3'd1,
    STEP_W2   = 3'd2,
    STEP_W3   = 3'd3,
    STEP_W4   = 3'd4
  } step_e;

  localparam int B_START    = 4;
  localparam int B_SINGLE   = 1;
  localparam int B_NEED4    = 0;
  localparam int B_UPM      = 0;
  localparam int B_AEOI     = 1;
  localparam int B_SFNM     = 4;
  localparam int B_KIND3    = 3;
  localparam int B_ROT      = 7;
  localparam int B_SL       = 6;
  localparam int B_EOI      = 5;
  localparam int B_SMM_EN   = 6;
  localparam int B_SMM      = 5;
  localparam int B_POLL     = 2;
  localparam int B_RDSEL_EN = 1;
  localparam int B_RDSEL    = 0;

endpackage

// File: rtl/icd_init_seq.sv
module icd_init_seq
  import intc_cmd_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int DATA_W    = 8,
  parameter int LVL_W     = 3,
  localparam int BASE_W   = DATA_W - LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_odd,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ready,
  output logic [BASE_W-1:0] vec_base,
  output logic              aeoi_en,
  output logic              sfn_en,
  output logic              start_hit,
  output logic              mask_we,
  output logic              op_we
);

  step_e             step_q, step_d;
  logic              ready_q, ready_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic              aeoi_q, aeoi_d;
  logic              sfn_q, sfn_d;
  logic              bad_start;

  always_comb begin
    start_hit = wr_en && !wr_odd && wr_data[B_START];
    op_we     = wr_en && !wr_odd && !wr_data[B_START] && ready_q;
    mask_we   = wr_en && wr_odd && (step_q == STEP_OP || step_q == STEP_FAIL);
    bad_start = wr_data[B_SINGLE] || !wr_data[B_NEED4];
  end

  always_comb begin
    step_d  = step_q;
    ready_d = ready_q;
    base_d  = base_q;
    aeoi_d  = aeoi_q;
    sfn_d   = sfn_q;
    if (start_hit) begin
      ready_d = 1'b0;
      step_d  = bad_start ? STEP_FAIL : STEP_W2;
    end else if (wr_en && wr_odd) begin
      case (step_q)
        STEP_W2: begin
          base_d = wr_data[DATA_W-1:LVL_W];
          step_d = STEP_W3;
        end
        STEP_W3: step_d = STEP_W4;
        STEP_W4: begin
          if (wr_data[B_UPM]) begin
            aeoi_d  = wr_data[B_AEOI];
            sfn_d   = IS_MASTER && wr_data[B_SFNM];
            ready_d = 1'b1;
            step_d  = STEP_OP;
          end
        end
        default: step_d = step_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= STEP_OP;
      ready_q <= 1'b0;
      base_q  <= '0;
      aeoi_q  <= 1'b0;
      sfn_q   <= 1'b0;
    end else begin
      step_q  <= step_d;
      ready_q <= ready_d;
      base_q  <= base_d;
      aeoi_q  <= aeoi_d;
      sfn_q   <= sfn_d;
    end
  end

  assign ready    = ready_q;
  assign vec_base = base_q;
  assign aeoi_en  = aeoi_q;
  assign sfn_en   = sfn_q;

  a_r3_bad_start_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_odd && wr_data[B_START] && (wr_data[B_SINGLE] || !wr_data[B_NEED4]))
    |=> (step_q == STEP_FAIL && !ready_q));

  a_r5_ready_from_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(wr_en && wr_odd && step_q == STEP_W4 && wr_data[B_UPM]));

  a_r4_seq_order: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == STEP_W4) |-> $past(step_q == STEP_W3 || step_q == STEP_W4));

endmodule

// File: rtl/icd_op_regs.sv
module icd_op_regs
  import intc_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_hit,
  input  logic              mask_we,
  input  logic              op_we,
  input  logic              poll_take,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] mask,
  output logic              smm_en,
  output logic              sel_isr,
  output logic              poll_armed,
  output logic              init_stb,
  output logic              cmd_stb,
  output logic              cmd_rot,
  output logic              cmd_sl,
  output logic              cmd_eoi,
  output logic [LVL_W-1:0]  cmd_lvl
);

  logic [DATA_W-1:0] mask_q, mask_d;
  logic              smm_q, smm_d, sel_q, sel_d, poll_q, poll_d;
  logic              init_q, init_d, stb_q, stb_d;
  logic              rot_q, sl_q, eoi_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              is_cmd3;

  always_comb begin
    is_cmd3 = op_we && wr_data[B_KIND3];
    mask_d  = mask_q;
    smm_d   = smm_q;
    sel_d   = sel_q;
    poll_d  = poll_q;
    if (poll_take) poll_d = 1'b0;
    if (mask_we)   mask_d = wr_data;
    if (is_cmd3) begin
      if (wr_data[B_SMM_EN]) smm_d = wr_data[B_SMM];
      if (wr_data[B_RDSEL_EN]) begin
        sel_d  = wr_data[B_RDSEL];
        poll_d = wr_data[B_POLL];
      end
    end
    if (start_hit) begin
      mask_d = '0;
      smm_d  = 1'b0;
      sel_d  = 1'b0;
      poll_d = 1'b0;
    end
    init_d = start_hit;
    stb_d  = op_we && !wr_data[B_KIND3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      smm_q  <= 1'b0;
      sel_q  <= 1'b0;
      poll_q <= 1'b0;
      init_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      smm_q  <= smm_d;
      sel_q  <= sel_d;
      poll_q <= poll_d;
      init_q <= init_d;
      stb_q  <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q <= 1'b0;
      sl_q  <= 1'b0;
      eoi_q <= 1'b0;
      lvl_q <= '0;
    end else if (stb_d) begin
      rot_q <= wr_data[B_ROT];
      sl_q  <= wr_data[B_SL];
      eoi_q <= wr_data[B_EOI];
      lvl_q <= wr_data[LVL_W-1:0];
    end
  end

  assign mask       = mask_q;
  assign smm_en     = smm_q;
  assign sel_isr    = sel_q;
  assign poll_armed = poll_q;
  assign init_stb   = init_q;
  assign cmd_stb    = stb_q;
  assign cmd_rot    = rot_q;
  assign cmd_sl     = sl_q;
  assign cmd_eoi    = eoi_q;
  assign cmd_lvl    = lvl_q;

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> (mask_q == '0 && !poll_q && !smm_q && !sel_q && init_q));

  a_r6_cmd_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(op_we && !wr_data[B_KIND3]));

  a_r8_poll_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !op_we && !start_hit) |=> !poll_q);

endmodule

// File: rtl/icd_read_port.sv
module icd_read_port #(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_odd,
  input  logic              poll_armed,
  input  logic              sel_isr,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] irr_in,
  input  logic [DATA_W-1:0] isr_in,
  input  logic              best_valid,
  input  logic [LVL_W-1:0]  best_lvl,
  output logic              poll_take,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack_stb,
  output logic [LVL_W-1:0]  ack_lvl
);

  localparam logic [DATA_W-1:0] POLL_HIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] data_q, data_d;
  logic              ack_q, ack_d;
  logic [LVL_W-1:0]  lvl_q;

  always_comb begin
    poll_take = rd_en && poll_armed;
    ack_d     = poll_take && best_valid;
    data_d    = data_q;
    if (poll_take) begin
      data_d = best_valid ? (POLL_HIT | DATA_W'(best_lvl)) : '0;
    end else if (rd_en) begin
      if (rd_odd)       data_d = mask;
      else if (sel_isr) data_d = isr_in;
      else              data_d = irr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ack_q  <= 1'b0;
      lvl_q  <= '0;
    end else begin
      data_q <= data_d;
      ack_q  <= ack_d;
      if (ack_d) lvl_q <= best_lvl;
    end
  end

  assign rd_data = data_q;
  assign ack_stb = ack_q;
  assign ack_lvl = lvl_q;

  a_r8_ack_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> $past(rd_en && poll_armed && best_valid));

  a_r8_poll_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> data_q[DATA_W-1]);

endmodule

// File: rtl/intc_cmd_decoder.sv
module intc_cmd_decoder #(
  parameter bit IS_MASTER = 1'b1,
  parameter int LEVELS    = 8,
  localparam int LVL_W    = $clog2(LEVELS),
  localparam int DATA_W   = LEVELS,
  localparam int BASE_W   = DATA_W - LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr_odd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] irr_in,
  input  logic [DATA_W-1:0] isr_in,
  input  logic              best_valid,
  input  logic [LVL_W-1:0]  best_lvl,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready,
  output logic [BASE_W-1:0] vec_base,
  output logic              aeoi_en,
  output logic              sfn_en,
  output logic              smm_en,
  output logic [DATA_W-1:0] mask_out,
  output logic              init_stb,
  output logic              cmd_stb,
  output logic              cmd_rot,
  output logic              cmd_sl,
  output logic              cmd_eoi,
  output logic [LVL_W-1:0]  cmd_lvl,
  output logic              ack_stb,
  output logic [LVL_W-1:0]  ack_lvl
);

  logic start_hit, mask_we, op_we, poll_take, poll_armed, sel_isr;

  icd_init_seq #(.IS_MASTER(IS_MASTER), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_odd(addr_odd), .wr_data(wr_data),
    .ready(ready), .vec_base(vec_base), .aeoi_en(aeoi_en), .sfn_en(sfn_en),
    .start_hit(start_hit), .mask_we(mask_we), .op_we(op_we)
  );

  icd_op_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .start_hit(start_hit), .mask_we(mask_we),
    .op_we(op_we), .poll_take(poll_take), .wr_data(wr_data), .mask(mask_out),
    .smm_en(smm_en), .sel_isr(sel_isr), .poll_armed(poll_armed),
    .init_stb(init_stb), .cmd_stb(cmd_stb), .cmd_rot(cmd_rot), .cmd_sl(cmd_sl),
    .cmd_eoi(cmd_eoi), .cmd_lvl(cmd_lvl)
  );

  icd_read_port #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_odd(addr_odd),
    .poll_armed(poll_armed), .sel_isr(sel_isr), .mask(mask_out),
    .irr_in(irr_in), .isr_in(isr_in), .best_valid(best_valid), .best_lvl(best_lvl),
    .poll_take(poll_take), .rd_data(rd_data), .ack_stb(ack_stb), .ack_lvl(ack_lvl)
  );

  a_r10_idle_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_odd && !wr_data[4] && !ready) |=> (!cmd_stb && !init_stb));

endmodule

// File: tb/intc_cmd_decoder_bench.sv
module intc_cmd_decoder_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, rd_en = 0, addr_odd = 0, best_valid = 0;
  logic [7:0] wr_data = 0, irr_in = 0, isr_in = 0;
  logic [2:0] best_lvl = 0;
  logic [7:0] rd_data, mask_out, s_rd, s_mask;
  logic [4:0] vec_base, s_vec;
  logic [2:0] cmd_lvl, ack_lvl, s_cl, s_al;
  logic ready, aeoi_en, sfn_en, smm_en, init_stb, cmd_stb, cmd_rot, cmd_sl, cmd_eoi, ack_stb;
  logic s_rdy, s_ae, s_sfn, s_smm, s_is, s_cs, s_cr, s_csl, s_ce, s_as;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intc_cmd_decoder #(.IS_MASTER(1'b1)) u_intc_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr_odd(addr_odd),
    .wr_data(wr_data), .irr_in(irr_in), .isr_in(isr_in), .best_valid(best_valid),
    .best_lvl(best_lvl), .rd_data(rd_data), .ready(ready), .vec_base(vec_base),
    .aeoi_en(aeoi_en), .sfn_en(sfn_en), .smm_en(smm_en), .mask_out(mask_out),
    .init_stb(init_stb), .cmd_stb(cmd_stb), .cmd_rot(cmd_rot), .cmd_sl(cmd_sl),
    .cmd_eoi(cmd_eoi), .cmd_lvl(cmd_lvl), .ack_stb(ack_stb), .ack_lvl(ack_lvl)
  );

  intc_cmd_decoder #(.IS_MASTER(1'b0)) u_intc_cmd_decoder_slave (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr_odd(addr_odd),
    .wr_data(wr_data), .irr_in(irr_in), .isr_in(isr_in), .best_valid(best_valid),
    .best_lvl(best_lvl), .rd_data(s_rd), .ready(s_rdy), .vec_base(s_vec),
    .aeoi_en(s_ae), .sfn_en(s_sfn), .smm_en(s_smm), .mask_out(s_mask),
    .init_stb(s_is), .cmd_stb(s_cs), .cmd_rot(s_cr), .cmd_sl(s_csl),
    .cmd_eoi(s_ce), .cmd_lvl(s_cl), .ack_stb(s_as), .ack_lvl(s_al)
  );

  // Behavioural reference model: step 0 operate, 1 error, 2..4 awaiting word
  int         m_step;
  bit         m_ready, m_aeoi, m_sfn, m_smm, m_isr, m_poll, m_init, m_cmd, m_ack;
  bit [4:0]   m_base;
  bit [7:0]   m_mask, m_rd, m_cmdbits;
  bit [2:0]   m_acklvl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_ready = 0; m_aeoi = 0; m_sfn = 0; m_smm = 0; m_isr = 0;
      m_poll = 0; m_init = 0; m_cmd = 0; m_ack = 0; m_base = 0; m_mask = 0;
      m_rd = 0; m_cmdbits = 0; m_acklvl = 0;
    end else begin
      bit rd_poll;
      bit [7:0] old_mask;
      old_mask = m_mask;
      rd_poll  = rd_en && m_poll;
      m_init   = 0;
      m_cmd    = 0;
      m_ack    = 0;
      if (rd_en) begin
        if (rd_poll) begin
          m_rd = best_valid ? (8'h80 + {5'd0, best_lvl}) : 8'h00;
          if (best_valid) begin m_ack = 1; m_acklvl = best_lvl; end
          m_poll = 0;
        end else if (addr_odd) m_rd = old_mask;
        else m_rd = m_isr ? isr_in : irr_in;
      end
      if (wr_en && !addr_odd) begin
        if (wr_data[4]) begin
          m_init = 1; m_ready = 0; m_mask = 0; m_smm = 0; m_isr = 0; m_poll = 0;
          m_step = (wr_data[1] || !wr_data[0]) ? 1 : 2;
        end else if (m_ready) begin
          if (wr_data[3]) begin
            if (wr_data[6]) m_smm = wr_data[5];
            if (wr_data[1]) begin m_isr = wr_data[0]; m_poll = wr_data[2]; end
          end else begin
            m_cmd = 1; m_cmdbits = wr_data;
          end
        end
      end else if (wr_en) begin
        if (m_step == 2) begin m_base = wr_data[7:3]; m_step = 3; end
        else if (m_step == 3) m_step = 4;
        else if (m_step == 4) begin
          if (wr_data[0]) begin
            m_aeoi = wr_data[1]; m_sfn = wr_data[4]; m_ready = 1; m_step = 0;
          end
        end else m_mask = wr_data;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 ready", ready, m_ready);
      check("R4 vec_base", vec_base, m_base);
      check("R5 aeoi_en", aeoi_en, m_aeoi);
      check("R5 sfn_en", sfn_en, m_sfn);
      check("R7 smm_en", smm_en, m_smm);
      check("R4 mask_out", mask_out, m_mask);
      check("R2 init_stb", init_stb, m_init);
      check("R6 cmd_stb", cmd_stb, m_cmd);
      if (m_cmd) begin
        check("R6 cmd_rot", cmd_rot, m_cmdbits[7]);
        check("R6 cmd_sl", cmd_sl, m_cmdbits[6]);
        check("R6 cmd_eoi", cmd_eoi, m_cmdbits[5]);
        check("R6 cmd_lvl", cmd_lvl, m_cmdbits[2:0]);
      end
      check("R9 rd_data", rd_data, m_rd);
      check("R8 ack_stb", ack_stb, m_ack);
      if (m_ack) check("R8 ack_lvl", ack_lvl, m_acklvl);
    end
  end

  task automatic wr(input bit odd, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr_odd = odd; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input bit odd);
    @(negedge clk);
    rd_en = 1; addr_odd = odd;
    @(negedge clk);
    rd_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready", ready, 0);
    check("R1 mask", mask_out, 0);
    check("R1 base", vec_base, 0);
    check("R1 modes", {aeoi_en, sfn_en, smm_en}, 0);
    check("R1 strobes", {init_stb, cmd_stb, ack_stb}, 0);
    check("R1 rd_data", rd_data, 0);
    irr_in = 8'hA5; isr_in = 8'h3C;
    rd(0);
    check("R1 irr selected", rd_data, 8'hA5);

    wr(0, 8'h20);
    check("R10 no cmd when idle", cmd_stb, 0);
    check("R10 no init when idle", init_stb, 0);

    wr(0, 8'h13);
    check("R3 single rejected", ready, 0);
    wr(1, 8'h5A);
    check("R3 odd loads mask", mask_out, 8'h5A);
    wr(0, 8'h10);
    check("R3 no fourth word", mask_out, 0);
    wr(1, 8'h33);
    check("R3 odd loads mask again", mask_out, 8'h33);

    wr(0, 8'h11);
    wr(1, 8'h27);
    check("R4 base", vec_base, 5'h04);
    wr(1, 8'hFF);
    check("R4 cascade word no effect", {ready, mask_out}, 0);
    wr(1, 8'h12);
    check("R5 mode rejected", ready, 0);
    wr(1, 8'h13);
    check("R5 ready", ready, 1);
    check("R5 aeoi", aeoi_en, 1);
    check("R5 sfn master", sfn_en, 1);
    check("R5 sfn slave", s_sfn, 0);

    wr(1, 8'hF0);
    rd(1);
    check("R9 mask read", rd_data, 8'hF0);
    wr(0, 8'hE3);
    wr(0, 8'h20);
    wr(0, 8'h45);
    wr(0, 8'h0B);
    rd(0);
    check("R7 isr selected", rd_data, 8'h3C);
    wr(0, 8'h0A);
    rd(0);
    check("R7 irr selected", rd_data, 8'hA5);
    wr(0, 8'h68);
    check("R7 smm on", smm_en, 1);
    wr(0, 8'h08);
    check("R7 smm unchanged w/o enable", smm_en, 1);
    wr(0, 8'h48);
    check("R7 smm off", smm_en, 0);

    best_valid = 1; best_lvl = 3'd5;
    wr(0, 8'h0E);
    rd(0);
    check("R8 poll hit", rd_data, 8'h85);
    rd(0);
    check("R8 poll cleared", rd_data, 8'hA5);
    best_valid = 0;
    wr(0, 8'h0E);
    rd(1);
    check("R8 poll miss", rd_data, 8'h00);
    best_valid = 1; best_lvl = 3'd2;
    wr(0, 8'h0F);
    rd(1);
    check("R8 poll odd address", rd_data, 8'h82);

    wr(0, 8'h6B);
    wr(0, 8'h0E);
    wr(0, 8'h11);
    check("R2 ready low", ready, 0);
    check("R2 mask cleared", mask_out, 0);
    check("R2 smm cleared", smm_en, 0);
    rd(0);
    check("R2 poll cleared, irr selected", rd_data, 8'hA5);
    wr(0, 8'hE1);
    check("R10 no cmd before ready", cmd_stb, 0);

    for (int i = 0; i < 8; i++) begin
      wr(0, 8'h11); wr(1, 8'(i * 8 + i)); wr(1, 8'h00); wr(1, 8'h01);
      check("R4 base sweep", vec_base, i);
      wr(0, 8'(8'h60 | i));
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule